// File: doc/BRIEF.md
# DMA Descriptor Loop Update Engine

This block carries out the per-channel loop bookkeeping of a descriptor-driven DMA. When `start` is pulsed, it latches a descriptor. The descriptor holds a source address, a destination address, a minor-loop word, a last-source adjustment, a current and a beginning iteration count, and major-loop link controls. The block then runs one minor loop as a series of single-byte read beats and write beats. Each beat uses its own valid/ready handshake. A minor loop always runs to its end once it has begun.

At the end of the minor loop, the block computes the next source address, the next destination address and the next iteration count. It presents them for one cycle on a write-back port. It can raise a start request to a linked channel. When the major loop is exhausted, it pulses `done`, adds the last-source adjustment and reloads the count from the beginning count. If the link-enable bits of the two counts disagree, the block sets a sticky configuration error and does not start the transfer.

The minor-loop word and the count fields have two layouts each. The selector bits inside each field pick the layout, so one descriptor format covers both plain and strided transfers.

Top module: `dma_loop_engine`

## Requirements
- R1: After a `start` pulse with consistent link bits, `busy` rises. The block issues read beats at source address S+i and write beats at destination D+i, with i counting from 0. A write beat follows each read beat, and the read and write requests are never both valid. While idle, neither request is valid.
- R2: A request holds `valid` with a stable address (and stable data for writes) until its `ready` is seen. Each written byte equals the byte returned by the preceding read.
- R3: Layout of the 32-bit minor word: bit 31 enables the source offset and bit 30 enables the destination offset. When both bits are clear, the whole word is the byte count. When either bit is set, bits 29:10 are a signed offset and bits 9:0 are the byte count.
- R4: A byte count of zero means 2^32 bytes when both offset enables are clear, and 1024 bytes when either enable is set.
- R5: At minor-loop end, the sign-extended offset is added to the next source address only if bit 31 is set, and to the next destination address only if bit 30 is set.
- R6: After the last write beat, `wb_valid` pulses for one cycle. With it come the next addresses (start address plus byte count plus adjustments) and the next count. The next count is the current count minus one, with the link bit and the channel number kept. After the pulse, `busy` is low.
- R7: When count bit 15 is set, bits 14:9 are a link channel and bits 8:0 are the count. If the major loop is not exhausted, `link_req` pulses together with `wb_valid` and `link_ch` carries that channel.
- R8: When count bit 15 is clear, bits 14:0 form a 15-bit count and no minor-loop link is raised.
- R9: The major loop is exhausted when the current count is 1 or 0 at minor-loop end. In that case the last-source adjustment is also added to the source address, the next count equals the beginning count, and `done` pulses for exactly one cycle together with `wb_valid`.
- R10: On major-loop exhaustion the minor-loop link is suppressed. `link_req` pulses with the major-link channel only if major linking is enabled.
- R11: If bit 15 of the current count differs from bit 15 of the beginning count at `start`, `cfg_err` is set and no beats are issued. `cfg_err` stays set until `err_clr` is pulsed.
- R12: After reset, `busy`, both request valids, `wb_valid`, `link_req`, `done` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Service request for this channel |
| err_clr | input | 1 | Clears the sticky configuration error |
| d_saddr | input | 32 | Descriptor source address |
| d_daddr | input | 32 | Descriptor destination address |
| d_minor | input | 32 | Minor-loop word: offset enables, offset, byte count |
| d_slast | input | 32 | Last-source adjustment |
| d_citer | input | 16 | Current iteration count with link control |
| d_biter | input | 16 | Beginning iteration count with link control |
| d_mlink_en | input | 1 | Major-loop link enable |
| d_mlink_ch | input | 6 | Major-loop link channel |
| rd_valid | output | 1 | Read beat request valid |
| rd_ready | input | 1 | Read beat accepted, data on rd_rdata |
| rd_addr | output | 32 | Read beat address |
| rd_rdata | input | 8 | Read byte |
| wr_valid | output | 1 | Write beat request valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | 32 | Write beat address |
| wr_data | output | 8 | Write byte |
| busy | output | 1 | Minor loop in progress |
| wb_valid | output | 1 | Write-back values valid (one cycle) |
| wb_saddr | output | 32 | Next source address |
| wb_daddr | output | 32 | Next destination address |
| wb_citer | output | 16 | Next current iteration count |
| link_req | output | 1 | Start request to a linked channel (one cycle) |
| link_ch | output | 6 | Linked channel number |
| done | output | 1 | Major loop exhausted (one cycle) |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The assertions assume that `start` arrives only while `busy` is low. A pulse during a loop is ignored, so a second loop never overlaps the first. They also assume that `rd_ready` and `wr_ready` are sampled as plain levels, with no other dependency on the request. The bench pulses `start` only after the previous write-back, or after an error was reported. It drives the two ready lines from a free-running pattern that is independent of the requests, either always high or stalling on a fixed period, so the hold properties see real back-pressure. The descriptor is latched at `start`, so the bench may change it freely afterwards.

// File: rtl/dle_pkg.sv
package dle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_UPD  = 2'd3
  } dle_state_t;
endpackage

// File: rtl/dle_minor_decode.sv
module dle_minor_decode #(
  parameter int AW   = 32,
  parameter int MW   = 32,
  parameter int OFFW = 20,
  parameter int SCW  = 10,
  localparam int CNTW = MW + 1
) (
  input  logic [MW-1:0]   minor,
  output logic            soff_en,
  output logic            doff_en,
  output logic [AW-1:0]   offset,
  output logic [CNTW-1:0] count
);
  localparam int FLDW = OFFW + SCW;

  logic            any_off;
  logic [CNTW-1:0] raw;

  always_comb begin
    soff_en = minor[MW-1];
    doff_en = minor[MW-2];
    any_off = soff_en | doff_en;
    offset  = {{(AW-OFFW){minor[FLDW-1]}}, minor[FLDW-1:SCW]};
    raw     = any_off ? {{(CNTW-SCW){1'b0}}, minor[SCW-1:0]} : {1'b0, minor};
    if (raw == '0)
      count = any_off ? (CNTW'(1) << SCW) : (CNTW'(1) << MW);
    else
      count = raw;
  end
endmodule

// File: rtl/dle_iter_decode.sv
module dle_iter_decode #(
  parameter int ITW  = 16,
  parameter int LCHW = 6,
  localparam int LONGW  = ITW - 1,
  localparam int SHORTW = ITW - 1 - LCHW
) (
  input  logic [ITW-1:0]   iter,
  output logic             elink,
  output logic [LCHW-1:0]  lch,
  output logic [LONGW-1:0] cnt
);
  always_comb begin
    elink = iter[ITW-1];
    lch   = iter[ITW-2 -: LCHW];
    cnt   = elink ? {{LCHW{1'b0}}, iter[SHORTW-1:0]} : iter[LONGW-1:0];
  end
endmodule

// File: rtl/dle_update.sv
module dle_update #(
  parameter int AW   = 32,
  parameter int ITW  = 16,
  parameter int LCHW = 6,
  localparam int LONGW  = ITW - 1,
  localparam int SHORTW = ITW - 1 - LCHW
) (
  input  logic [AW-1:0]   sa,
  input  logic [AW-1:0]   da,
  input  logic            soff_en,
  input  logic            doff_en,
  input  logic [AW-1:0]   offset,
  input  logic [AW-1:0]   slast,
  input  logic [ITW-1:0]  citer,
  input  logic [ITW-1:0]  biter,
  input  logic            mlink_en,
  input  logic [LCHW-1:0] mlink_ch,
  output logic [AW-1:0]   sa_n,
  output logic [AW-1:0]   da_n,
  output logic [ITW-1:0]  citer_n,
  output logic            major_done,
  output logic            link_n,
  output logic [LCHW-1:0] link_ch_n
);
  logic             elink;
  logic [LCHW-1:0]  lch;
  logic [LONGW-1:0] cnt, dec;

  dle_iter_decode #(.ITW(ITW), .LCHW(LCHW)) u_cur (
    .iter(citer), .elink(elink), .lch(lch), .cnt(cnt)
  );

  always_comb begin
    major_done = (cnt <= LONGW'(1));
    dec        = cnt - LONGW'(1);
    sa_n = sa + (soff_en ? offset : '0) + (major_done ? slast : '0);
    da_n = da + (doff_en ? offset : '0);
    if (major_done)
      citer_n = biter;
    else if (elink)
      citer_n = {1'b1, lch, dec[SHORTW-1:0]};
    else
      citer_n = {1'b0, dec};
    if (major_done) begin
      link_n    = mlink_en;
      link_ch_n = mlink_ch;
    end else begin
      link_n    = elink;
      link_ch_n = lch;
    end
  end
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
  import dle_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 8,
  parameter int MW   = 32,
  parameter int OFFW = 20,
  parameter int SCW  = 10,
  parameter int ITW  = 16,
  parameter int LCHW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            err_clr,
  input  logic [AW-1:0]   d_saddr,
  input  logic [AW-1:0]   d_daddr,
  input  logic [MW-1:0]   d_minor,
  input  logic [AW-1:0]   d_slast,
  input  logic [ITW-1:0]  d_citer,
  input  logic [ITW-1:0]  d_biter,
  input  logic            d_mlink_en,
  input  logic [LCHW-1:0] d_mlink_ch,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_rdata,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            busy,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_saddr,
  output logic [AW-1:0]   wb_daddr,
  output logic [ITW-1:0]  wb_citer,
  output logic            link_req,
  output logic [LCHW-1:0] link_ch,
  output logic            done,
  output logic            cfg_err
);
  localparam int CNTW = MW + 1;

  dle_state_t      state;
  logic [AW-1:0]   sa_q, da_q, off_q, slast_q;
  logic [CNTW-1:0] cnt_q;
  logic            soff_q, doff_q, mlen_q;
  logic [ITW-1:0]  citer_q, biter_q;
  logic [LCHW-1:0] mlch_q;
  logic [DW-1:0]   byte_q;

  logic            dec_soff, dec_doff;
  logic [AW-1:0]   dec_off;
  logic [CNTW-1:0] dec_cnt;
  logic            bad_link;

  logic [AW-1:0]   sa_n, da_n;
  logic [ITW-1:0]  citer_n;
  logic            major_done, link_n;
  logic [LCHW-1:0] link_ch_n;

  dle_minor_decode #(.AW(AW), .MW(MW), .OFFW(OFFW), .SCW(SCW)) u_minor (
    .minor(d_minor), .soff_en(dec_soff), .doff_en(dec_doff),
    .offset(dec_off), .count(dec_cnt)
  );

  dle_update #(.AW(AW), .ITW(ITW), .LCHW(LCHW)) u_upd (
    .sa(sa_q), .da(da_q), .soff_en(soff_q), .doff_en(doff_q),
    .offset(off_q), .slast(slast_q), .citer(citer_q), .biter(biter_q),
    .mlink_en(mlen_q), .mlink_ch(mlch_q),
    .sa_n(sa_n), .da_n(da_n), .citer_n(citer_n),
    .major_done(major_done), .link_n(link_n), .link_ch_n(link_ch_n)
  );

  assign bad_link = d_citer[ITW-1] ^ d_biter[ITW-1];

  assign busy     = (state != ST_IDLE);
  assign rd_valid = (state == ST_RD);
  assign wr_valid = (state == ST_WR);
  assign rd_addr  = sa_q;
  assign wr_addr  = da_q;
  assign wr_data  = byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sa_q     <= '0;
      da_q     <= '0;
      off_q    <= '0;
      slast_q  <= '0;
      cnt_q    <= '0;
      soff_q   <= 1'b0;
      doff_q   <= 1'b0;
      mlen_q   <= 1'b0;
      mlch_q   <= '0;
      citer_q  <= '0;
      biter_q  <= '0;
      byte_q   <= '0;
      wb_valid <= 1'b0;
      wb_saddr <= '0;
      wb_daddr <= '0;
      wb_citer <= '0;
      link_req <= 1'b0;
      link_ch  <= '0;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      wb_valid <= 1'b0;
      link_req <= 1'b0;
      done     <= 1'b0;
      if (err_clr) cfg_err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (bad_link) begin
              cfg_err <= 1'b1;
            end else begin
              sa_q    <= d_saddr;
              da_q    <= d_daddr;
              off_q   <= dec_off;
              cnt_q   <= dec_cnt;
              soff_q  <= dec_soff;
              doff_q  <= dec_doff;
              slast_q <= d_slast;
              citer_q <= d_citer;
              biter_q <= d_biter;
              mlen_q  <= d_mlink_en;
              mlch_q  <= d_mlink_ch;
              state   <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (rd_ready) begin
            byte_q <= rd_rdata;
            state  <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_ready) begin
            sa_q  <= sa_q + AW'(1);
            da_q  <= da_q + AW'(1);
            cnt_q <= cnt_q - CNTW'(1);
            state <= (cnt_q == CNTW'(1)) ? ST_UPD : ST_RD;
          end
        end
        ST_UPD: begin
          wb_valid <= 1'b1;
          wb_saddr <= sa_n;
          wb_daddr <= da_n;
          wb_citer <= citer_n;
          link_req <= link_n;
          link_ch  <= link_ch_n;
          done     <= major_done;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dle_checker.sv
module dle_checker #(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          wb_valid,
  input logic          link_req,
  input logic          done,
  input logic          cfg_err,
  input logic          err_clr
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R2
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_valid)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_valid && !wr_valid); // R1
  AST_RD_TO_WR: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_ready |=> wr_valid); // R1
  AST_WB_PULSE: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid); // R6
  AST_LINK_WITH_WB: assert property (@(posedge clk) disable iff (rst)
    link_req |-> wb_valid); // R7
  AST_DONE_WITH_WB: assert property (@(posedge clk) disable iff (rst)
    done |-> wb_valid); // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err && !err_clr |=> cfg_err); // R11
endmodule

bind dma_loop_engine dle_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .wb_valid(wb_valid),
  .link_req(link_req), .done(done), .cfg_err(cfg_err), .err_clr(err_clr)
);

// File: tb/tb_dma_loop_engine.sv
module tb_dma_loop_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, err_clr = 1'b0;
  logic [31:0] d_saddr = '0, d_daddr = '0, d_minor = '0, d_slast = '0;
  logic [15:0] d_citer = '0, d_biter = '0;
  logic        d_mlink_en = 1'b0;
  logic [5:0]  d_mlink_ch = '0;
  logic        rd_valid, wr_valid, busy, wb_valid, link_req, done, cfg_err;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_addr, wr_addr, wb_saddr, wb_daddr;
  logic [7:0]  rd_rdata, wr_data;
  logic [15:0] wb_citer;
  logic [5:0]  link_ch;
  logic        stall = 1'b0;
  int unsigned cyc = 0;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign rd_rdata = rd_addr[7:0] ^ 8'hA5;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_ready <= stall ? (cyc % 3 == 1) : 1'b1;
    wr_ready <= stall ? cyc[0] : 1'b1;
  end

  dma_loop_engine dut (
    .clk(clk), .rst(rst), .start(start), .err_clr(err_clr),
    .d_saddr(d_saddr), .d_daddr(d_daddr), .d_minor(d_minor), .d_slast(d_slast),
    .d_citer(d_citer), .d_biter(d_biter), .d_mlink_en(d_mlink_en),
    .d_mlink_ch(d_mlink_ch), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rdata(rd_rdata), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .wb_valid(wb_valid), .wb_saddr(wb_saddr), .wb_daddr(wb_daddr),
    .wb_citer(wb_citer), .link_req(link_req), .link_ch(link_ch),
    .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    summary();
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs one minor loop and checks beats and write-back values.
  task automatic run_xfer(input string req, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] minor, input logic [31:0] slast,
                          input logic [15:0] ci, input logic [15:0] bi,
                          input bit mlen, input logic [5:0] mlch,
                          input int exp_n, input logic [31:0] exp_sa,
                          input logic [31:0] exp_da, input logic [15:0] exp_ci,
                          input bit exp_link, input logic [5:0] exp_lch, input bit exp_done);
    int rd_i = 0, wr_i = 0, bad = 0, t = 0;
    bit got = 1'b0;
    @(negedge clk);
    d_saddr = s; d_daddr = d; d_minor = minor; d_slast = slast;
    d_citer = ci; d_biter = bi; d_mlink_en = mlen; d_mlink_ch = mlch;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {req, " R1 busy"}, busy, 1);
    while (!got && t < 5000) begin
      if (rd_valid && rd_ready) begin
        if (rd_addr != s + rd_i) bad++;
        rd_i++;
      end
      if (wr_valid && wr_ready) begin
        if (wr_addr != d + wr_i) bad++;
        if (wr_data != ((s[7:0] + 8'(wr_i)) ^ 8'hA5)) bad++;
        wr_i++;
      end
      if (wb_valid) begin
        got = 1'b1;
      end else begin
        @(negedge clk);
        t++;
      end
    end
    chk(got, {req, " R6 write-back seen"}, got, 1);
    chk(bad == 0, {req, " R1 R2 beat address/data"}, bad, 0);
    chk(wr_i == exp_n, {req, " R3 R4 beat count"}, wr_i, exp_n);
    chk(wb_saddr == exp_sa, {req, " R5 R6 next source"}, wb_saddr, exp_sa);
    chk(wb_daddr == exp_da, {req, " R5 R6 next destination"}, wb_daddr, exp_da);
    chk(wb_citer == exp_ci, {req, " R6 next count"}, wb_citer, exp_ci);
    chk(link_req == exp_link, {req, " R7 R10 link request"}, link_req, exp_link);
    if (exp_link) chk(link_ch == exp_lch, {req, " R7 R10 link channel"}, link_ch, exp_lch);
    chk(done == exp_done, {req, " R9 done"}, done, exp_done);
    @(negedge clk);
    chk(!wb_valid && !done && !link_req && !busy, {req, " R6 R9 single pulse"},
        {wb_valid, done, link_req, busy}, 0);
  endtask

  task automatic t_reset();
    chk({busy, rd_valid, wr_valid, wb_valid, link_req, done, cfg_err} == 7'b0,
        "R12 reset state", {busy, rd_valid, wr_valid, wb_valid, link_req, done, cfg_err}, 0);
  endtask

  task automatic t_plain();
    run_xfer("R1 plain", 32'h1000, 32'h2000, 32'd4, 32'h0, 16'h0003, 16'h0003, 1'b0, 6'd0,
             4, 32'h1004, 32'h2004, 16'h0002, 1'b0, 6'd0, 1'b0);
  endtask

  task automatic t_offsets();
    run_xfer("R5 both offsets", 32'h3000, 32'h4000, {2'b11, 20'hFFFF8, 10'd3}, 32'h0,
             16'h000A, 16'h000A, 1'b0, 6'd0,
             3, 32'h3003 - 32'd8, 32'h4003 - 32'd8, 16'h0009, 1'b0, 6'd0, 1'b0);
    run_xfer("R5 source offset only", 32'h3100, 32'h4100, {2'b10, 20'h00010, 10'd2}, 32'h0,
             16'h0005, 16'h0005, 1'b0, 6'd0,
             2, 32'h3102 + 32'h10, 32'h4102, 16'h0004, 1'b0, 6'd0, 1'b0);
    run_xfer("R3 R5 dest offset only", 32'h3200, 32'h4200, {2'b01, 20'h00040, 10'd1}, 32'h0,
             16'h0005, 16'h0005, 1'b0, 6'd0,
             1, 32'h3201, 32'h4201 + 32'h40, 16'h0004, 1'b0, 6'd0, 1'b0);
  endtask

  task automatic t_minor_link();
    run_xfer("R7 minor link", 32'h6000, 32'h7000, 32'd2, 32'h0,
             {1'b1, 6'd5, 9'd4}, {1'b1, 6'd5, 9'd4}, 1'b0, 6'd0,
             2, 32'h6002, 32'h7002, {1'b1, 6'd5, 9'd3}, 1'b1, 6'd5, 1'b0);
  endtask

  task automatic t_wide_count();
    run_xfer("R8 15-bit count", 32'h6100, 32'h7100, 32'd1, 32'h0,
             16'h7FFF, 16'h7FFF, 1'b0, 6'd0,
             1, 32'h6101, 32'h7101, 16'h7FFE, 1'b0, 6'd0, 1'b0);
  endtask

  task automatic t_major();
    run_xfer("R9 major done", 32'h5000, 32'h5800, 32'd5, 32'hFFFF_FFF0,
             16'h0001, 16'h0007, 1'b1, 6'd9,
             5, 32'h4FF5, 32'h5805, 16'h0007, 1'b1, 6'd9, 1'b1);
    run_xfer("R10 minor link suppressed", 32'h5100, 32'h5900, 32'd2, 32'h20,
             {1'b1, 6'd5, 9'd1}, {1'b1, 6'd5, 9'd6}, 1'b0, 6'd0,
             2, 32'h5122, 32'h5902, {1'b1, 6'd5, 9'd6}, 1'b0, 6'd0, 1'b1);
    run_xfer("R10 major link wins", 32'h5200, 32'h5A00, 32'd1, 32'h0,
             {1'b1, 6'd5, 9'd1}, {1'b1, 6'd5, 9'd2}, 1'b1, 6'd12,
             1, 32'h5201, 32'h5A01, {1'b1, 6'd5, 9'd2}, 1'b1, 6'd12, 1'b1);
  endtask

  task automatic t_stall();
    stall = 1'b1;
    run_xfer("R2 back-pressure", 32'h8000, 32'h9000, 32'd6, 32'h0, 16'h0002, 16'h0002,
             1'b0, 6'd0, 6, 32'h8006, 32'h9006, 16'h0001, 1'b0, 6'd0, 1'b0);
    stall = 1'b0;
  endtask

  task automatic t_zero_offset_mode();
    run_xfer("R4 zero count offset mode", 32'hA000, 32'hB000, {2'b10, 20'h0, 10'd0}, 32'h0,
             16'h0003, 16'h0003, 1'b0, 6'd0,
             1024, 32'hA400, 32'hB400, 16'h0002, 1'b0, 6'd0, 1'b0);
  endtask

  task automatic t_zero_full();
    int beats = 0;
    bit wb_seen = 1'b0;
    @(negedge clk);
    d_saddr = 32'hC000; d_daddr = 32'hD000; d_minor = 32'h0;
    d_citer = 16'h0002; d_biter = 16'h0002; d_mlink_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (600) begin
      if (wr_valid && wr_ready) beats++;
      if (wb_valid) wb_seen = 1'b1;
      @(negedge clk);
    end
    chk(busy && !wb_seen && beats >= 299, "R4 zero count runs past 299 bytes",
        beats, 299);
    do_reset();
    t_reset();
  endtask

  task automatic t_cfg_err();
    @(negedge clk);
    d_citer = {1'b1, 6'd3, 9'd2}; d_biter = {1'b0, 15'd2};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(cfg_err == 1'b1, "R11 error set", cfg_err, 1);
    chk(!busy && !rd_valid && !wr_valid, "R11 no beats", {busy, rd_valid, wr_valid}, 0);
    repeat (5) @(negedge clk);
    chk(cfg_err == 1'b1, "R11 error sticky", cfg_err, 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(cfg_err == 1'b0, "R11 error cleared", cfg_err, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_plain();
    t_offsets();
    t_minor_link();
    t_wide_count();
    t_major();
    t_stall();
    t_zero_offset_mode();
    t_cfg_err();
    t_zero_full();
    t_plain();
    summary();
  end
endmodule